// File: doc/BRIEF.md
# Cubic Polynomial Error Corrector

This block produces, for every input code of a high-resolution DAC, a small digital correction code that drives a low-resolution correction DAC. The two analog outputs are summed outside the block. Four signed coefficients of a third-order polynomial are computed off-line by a calibration routine and written into the block. At run time the block evaluates the polynomial of the normalized input code at one code per clock. It rounds the result to the nearest correction-DAC step and saturates it, so the residual nonlinearity of the summed output stays within half an LSB.

The input code `x` is read as a fraction `code / 2^CODE_W` in [0,1). Coefficients are given in units of one correction-DAC step with `FRAC_W` fractional bits. One step equals 3/64 of a main-DAC LSB, so the 6-bit two's-complement correction range covers exactly ±1.5 LSB. Coefficient writes go to a staging set. A commit strobe moves the staging set into the active set only while no evaluation is using the coefficients, so no single result mixes two coefficient sets.

Top module: `pce_corrector`

## Requirements
- R1: With the default widths, the result follows Horner form with a floor after each scaling step. acc0 = b3, acc1 = floor(acc0·code/2^14) + b2, acc2 = floor(acc1·code/2^14) + b1, acc3 = floor(acc2·code/2^14) + b0, where code is read as unsigned.
- R2: Coefficients are 16-bit two's complement with 8 fractional bits, in units of one correction step. `corr_code` is 6-bit two's complement in whole steps, so the range -32..31 spans ±1.5 LSB of the main DAC.
- R3: The output equals (acc3 + 128) >>> 8, which rounds to the nearest step with halves going toward plus infinity. That value is then clamped to -32..31. It saturates and never wraps, even when all four coefficients are at their extreme values.
- R4: A code presented with `code_valid` high at a rising edge yields `corr_valid` high exactly four edges later. Codes may arrive on every clock and each one yields one result.
- R5: While `corr_valid` is low, `corr_code` keeps its last value.
- R6: `coef_we` writes `coef_wdata` into the staging coefficient selected by `coef_sel` (0 = b0, 1 = b1, 2 = b2, 3 = b3). A staging write without a commit has no effect on results.
- R7: A `coef_commit` pulse copies the staging set into the active set at the first rising edge at which `code_valid` is low and no code entered at either of the two previous edges. Every code that entered before that edge is evaluated wholly with the old set, and every later code wholly with the new set.
- R8: Synchronous active-high reset clears `corr_valid`, `corr_code`, a pending commit and both coefficient sets, so later results are zero until a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coef_we | input | 1 | Write strobe for the staging coefficient set |
| coef_sel | input | 2 | Staging coefficient index (0 = b0 … 3 = b3) |
| coef_wdata | input | COEF_W | Coefficient value, two's complement, FRAC_W fractional bits |
| coef_commit | input | 1 | Request to move the staging set into the active set |
| code_valid | input | 1 | Input code qualifier |
| code_in | input | CODE_W | Main DAC input code |
| corr_valid | output | 1 | Correction result qualifier |
| corr_code | output | CORR_W | Correction DAC code, two's complement |

## Verification
The hardest case to reach is a commit that arrives while codes are still in flight, because the coefficient switch must wait for the pipeline to drain. The bench streams six back-to-back codes and raises the commit in the middle of the stream. It checks that all six results still carry the old correction. It then checks that the first code after the gap carries the new one. Saturation with all four coefficients at their extreme values is reached through table entries that drive the internal accumulator close to its width limit.

// File: rtl/pce_pkg.sv
package pce_pkg;

    typedef enum logic [1:0] {
        CF_B0 = 2'd0,
        CF_B1 = 2'd1,
        CF_B2 = 2'd2,
        CF_B3 = 2'd3
    } coef_sel_e;

    localparam int NUM_COEF = 4;

    // round to nearest, halves toward +inf, dropping f fractional bits
    function automatic longint round_half_up(longint v, int f);
        longint half;
        half = longint'(1) <<< (f - 1);
        return (v + half) >>> f;
    endfunction

    // clamp into the w-bit two's-complement range
    function automatic longint clamp_signed(longint v, int w);
        longint hi;
        longint lo;
        hi = (longint'(1) <<< (w - 1)) - 1;
        lo = -(longint'(1) <<< (w - 1));
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

endpackage

// File: rtl/pce_coef_bank.sv
module pce_coef_bank
    import pce_pkg::*;
#(
    parameter int COEF_W = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  coef_sel_e                    wr_sel,
    input  logic [COEF_W-1:0]            wr_data,
    input  logic                         commit,
    input  logic                         idle,
    output logic [NUM_COEF*COEF_W-1:0]   act_flat,
    output logic [NUM_COEF*COEF_W-1:0]   shd_flat
);

    logic pend_q;
    logic apply;

    assign apply = (commit || pend_q) && idle;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= (commit || pend_q) && !idle;
    end

    for (genvar g = 0; g < NUM_COEF; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                shd_flat[g*COEF_W +: COEF_W] <= '0;
            else if (wr_en && (wr_sel == coef_sel_e'(g)))
                shd_flat[g*COEF_W +: COEF_W] <= wr_data;
        end

        always_ff @(posedge clk) begin
            if (rst)
                act_flat[g*COEF_W +: COEF_W] <= '0;
            else if (apply)
                act_flat[g*COEF_W +: COEF_W] <= shd_flat[g*COEF_W +: COEF_W];
        end
    end

endmodule

// File: rtl/pce_horner_stage.sv
module pce_horner_stage #(
    parameter int CODE_W = 14,
    parameter int COEF_W = 16,
    parameter int ACC_W  = 18
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     vld_in,
    input  logic signed [ACC_W-1:0]  acc_in,
    input  logic [CODE_W-1:0]        code,
    input  logic signed [COEF_W-1:0] coef,
    output logic                     vld_out,
    output logic signed [ACC_W-1:0]  acc_out
);

    localparam int PROD_W = ACC_W + CODE_W + 1;

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;
    logic signed [ACC_W-1:0]  nxt;

    always_comb begin
        prod   = $signed(acc_in) * $signed({1'b0, code});
        scaled = prod >>> CODE_W;
        nxt    = ACC_W'(scaled) + ACC_W'(coef);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_out <= 1'b0;
            acc_out <= '0;
        end else begin
            vld_out <= vld_in;
            if (vld_in) acc_out <= nxt;
        end
    end

endmodule

// File: rtl/pce_out_quant.sv
module pce_out_quant
    import pce_pkg::*;
#(
    parameter int ACC_W  = 18,
    parameter int FRAC_W = 8,
    parameter int CORR_W = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    vld_in,
    input  logic signed [ACC_W-1:0] acc_in,
    output logic                    vld_out,
    output logic [CORR_W-1:0]       code_out
);

    longint rounded;
    longint limited;

    always_comb begin
        rounded = round_half_up(longint'(acc_in), FRAC_W);
        limited = clamp_signed(rounded, CORR_W);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_out  <= 1'b0;
            code_out <= '0;
        end else begin
            vld_out <= vld_in;
            if (vld_in) code_out <= CORR_W'(limited);
        end
    end

endmodule

// File: rtl/pce_corrector.sv
module pce_corrector
    import pce_pkg::*;
#(
    parameter int CODE_W = 14,
    parameter int COEF_W = 16,
    parameter int FRAC_W = 8,
    parameter int CORR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              coef_we,
    input  logic [1:0]        coef_sel,
    input  logic [COEF_W-1:0] coef_wdata,
    input  logic              coef_commit,
    input  logic              code_valid,
    input  logic [CODE_W-1:0] code_in,
    output logic              corr_valid,
    output logic [CORR_W-1:0] corr_code
);

    localparam int ACC_W   = COEF_W + 2;
    localparam int N_STAGE = NUM_COEF - 1;

    logic [NUM_COEF*COEF_W-1:0] coef_act_flat;
    logic [NUM_COEF*COEF_W-1:0] coef_shd_flat;
    logic                       pipe_idle;

    logic                    vld_l  [0:N_STAGE];
    logic signed [ACC_W-1:0] acc_l  [0:N_STAGE];
    logic [CODE_W-1:0]       code_l [0:N_STAGE-1];

    pce_coef_bank #(.COEF_W(COEF_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (coef_we),
        .wr_sel   (coef_sel_e'(coef_sel)),
        .wr_data  (coef_wdata),
        .commit   (coef_commit),
        .idle     (pipe_idle),
        .act_flat (coef_act_flat),
        .shd_flat (coef_shd_flat)
    );

    // idle: no code entering and none in stages that still read coefficients
    always_comb begin
        pipe_idle = !code_valid;
        for (int s = 1; s < N_STAGE; s++)
            if (vld_l[s]) pipe_idle = 1'b0;
    end

    assign vld_l[0]  = code_valid;
    assign acc_l[0]  = ACC_W'($signed(coef_act_flat[N_STAGE*COEF_W +: COEF_W]));
    assign code_l[0] = code_in;

    for (genvar s = 1; s < N_STAGE; s++) begin : g_code_dly
        always_ff @(posedge clk) begin
            if (rst)           code_l[s] <= '0;
            else if (vld_l[s-1]) code_l[s] <= code_l[s-1];
        end
    end

    for (genvar s = 0; s < N_STAGE; s++) begin : g_stage
        pce_horner_stage #(
            .CODE_W (CODE_W),
            .COEF_W (COEF_W),
            .ACC_W  (ACC_W)
        ) u_stage (
            .clk     (clk),
            .rst     (rst),
            .vld_in  (vld_l[s]),
            .acc_in  (acc_l[s]),
            .code    (code_l[s]),
            .coef    ($signed(coef_act_flat[(N_STAGE-1-s)*COEF_W +: COEF_W])),
            .vld_out (vld_l[s+1]),
            .acc_out (acc_l[s+1])
        );
    end

    pce_out_quant #(
        .ACC_W  (ACC_W),
        .FRAC_W (FRAC_W),
        .CORR_W (CORR_W)
    ) u_quant (
        .clk      (clk),
        .rst      (rst),
        .vld_in   (vld_l[N_STAGE]),
        .acc_in   (acc_l[N_STAGE]),
        .vld_out  (corr_valid),
        .code_out (corr_code)
    );

endmodule

// File: rtl/pce_corrector_chk.sv
module pce_corrector_chk #(
    parameter int COEF_W = 16,
    parameter int CORR_W = 6
) (
    input logic                clk,
    input logic                rst,
    input logic                code_valid,
    input logic                coef_commit,
    input logic                corr_valid,
    input logic [CORR_W-1:0]   corr_code,
    input logic [4*COEF_W-1:0] coef_act,
    input logic [4*COEF_W-1:0] coef_shd,
    input logic                pipe_idle
);

    logic [2:0] age;

    always_ff @(posedge clk) begin
        if (rst)              age <= '0;
        else if (age != 3'd5) age <= age + 3'd1;
    end

    p_latency_r4: assert property (@(posedge clk) disable iff (rst)
        (age == 3'd5) |-> (corr_valid == $past(code_valid, 4)));

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (age != 3'd0 && !corr_valid) |-> $stable(corr_code));

    p_switch_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (age != 3'd0 && !$stable(coef_act)) |-> $past(pipe_idle));

    p_commit_apply_r7: assert property (@(posedge clk) disable iff (rst)
        (age != 3'd0 && coef_commit && pipe_idle) |=> (coef_act == $past(coef_shd)));

    p_reset_clear_r8: assert property (@(posedge clk)
        rst |=> (!corr_valid && corr_code == '0 && coef_act == '0));

endmodule

bind pce_corrector pce_corrector_chk #(.COEF_W(COEF_W), .CORR_W(CORR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .code_valid  (code_valid),
    .coef_commit (coef_commit),
    .corr_valid  (corr_valid),
    .corr_code   (corr_code),
    .coef_act    (coef_act_flat),
    .coef_shd    (coef_shd_flat),
    .pipe_idle   (pipe_idle)
);

// File: tb/tb_pce_corrector.sv
`timescale 1ns/1ps
module tb_pce_corrector;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        coef_we = 1'b0;
    logic [1:0]  coef_sel = 2'd0;
    logic [15:0] coef_wdata = '0;
    logic        coef_commit = 1'b0;
    logic        code_valid = 1'b0;
    logic [13:0] code_in = '0;
    logic        corr_valid;
    logic [5:0]  corr_code;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pce_corrector dut (
        .clk(clk), .rst(rst), .coef_we(coef_we), .coef_sel(coef_sel),
        .coef_wdata(coef_wdata), .coef_commit(coef_commit),
        .code_valid(code_valid), .code_in(code_in),
        .corr_valid(corr_valid), .corr_code(corr_code)
    );

    // columns: b0, b1, b2, b3, code, expected signed correction
    localparam int NV = 13;
    localparam int TB0 [NV] = '{1280, 0, 0, 0, 0, 384, -384, 383, 32767, -32768, 32767, -32768, 0};
    localparam int TB1 [NV] = '{0, 4096, 0, 0, 4096, 0, 0, 0, 0, 0, 32767, -32768, -1};
    localparam int TB2 [NV] = '{0, 0, 4096, 0, 0, 0, 0, 0, 0, 0, 32767, -32768, 0};
    localparam int TB3 [NV] = '{0, 0, 0, 2048, 0, 0, 0, 0, 0, 0, 32767, -32768, 0};
    localparam int TCODE[NV] = '{0, 8192, 8192, 8192, 16383, 100, 100, 5, 1, 1, 16383, 16383, 1};
    localparam int TEXP [NV] = '{5, 8, 4, 1, 16, 2, -1, 1, 31, -32, 31, -32, 0};
    localparam string TREQ[NV] = '{"R1", "R1", "R1", "R1", "R1", "R3", "R3", "R3", "R3", "R3", "R3", "R3", "R2"};

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_coef(input int idx, input int val);
        @(negedge clk);
        coef_we = 1'b1; coef_sel = 2'(idx); coef_wdata = 16'(val);
        @(negedge clk);
        coef_we = 1'b0;
    endtask

    task automatic commit_now();
        @(negedge clk);
        coef_commit = 1'b1;
        @(negedge clk);
        coef_commit = 1'b0;
    endtask

    // present one code, return the result four edges later
    task automatic run_code(input int c, input bit chk_early, output bit v, output int r);
        @(negedge clk);
        code_valid = 1'b1; code_in = 14'(c);
        @(negedge clk);
        code_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        if (chk_early) check(corr_valid == 1'b0, "R4 early", corr_valid, 0);
        @(negedge clk);
        v = corr_valid;
        r = $signed(corr_code);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R4 watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit v;
        int r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: reset state and zero coefficients
        check(corr_valid == 1'b0, "R8 valid", corr_valid, 0);
        check(corr_code == 6'd0, "R8 code", corr_code, 0);
        run_code(12345, 1'b1, v, r);
        check(v && r == 0, "R8 zero coefs", r, 0);

        // vector table (R1, R2, R3)
        for (int i = 0; i < NV; i++) begin
            write_coef(0, TB0[i]);
            write_coef(1, TB1[i]);
            write_coef(2, TB2[i]);
            write_coef(3, TB3[i]);
            commit_now();
            run_code(TCODE[i], 1'b0, v, r);
            check(v && r == TEXP[i], TREQ[i], r, TEXP[i]);
        end

        // R6: staging write without commit has no effect
        write_coef(0, 1280);
        write_coef(1, 0);
        write_coef(2, 0);
        write_coef(3, 0);
        commit_now();
        write_coef(0, 2560);
        run_code(777, 1'b0, v, r);
        check(v && r == 5, "R6 no commit", r, 5);

        // R7 and R4: commit raised mid-stream is deferred
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (i >= 4) check(corr_valid && $signed(corr_code) == 5, "R7 stream old", $signed(corr_code), 5);
            if (i < 6) begin
                code_valid = 1'b1; code_in = 14'(i * 1000);
                coef_commit = (i == 2);
            end else begin
                code_valid = 1'b0; coef_commit = 1'b0;
            end
        end
        run_code(4000, 1'b0, v, r);
        check(v && r == 10, "R7 new set", r, 10);

        // R5: output holds while not valid
        repeat (3) @(negedge clk);
        check(corr_valid == 1'b0, "R5 valid low", corr_valid, 0);
        check($signed(corr_code) == 10, "R5 hold", $signed(corr_code), 10);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule